// File: doc/BRIEF.md
# Dual-Level Maskable Interrupt Controller

This block collects level-sensitive request lines from on-chip peripherals and folds them into two request outputs for a processor core. One output is a normal interrupt. The other is a fast interrupt with higher priority. Each level keeps its own enable mask. The core reads each level's raw and masked views over a simple synchronous register bus. It works out the source from the masked view, because the block produces no vector or priority code.

Enable masks can only be set by writing ones to the enable register. A separate clear register removes bits. An enable bit can be active in at most one of the two levels, and setting it in one level drops it from the other. Source position 0 of both levels carries the fast output itself, so the normal level can see that a fast request is pending. Source position 1 of each level is a software-programmed request that bypasses the mask. Peripheral lines occupy positions 2 and up.

Top module: `dual_irq_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released until the first write, every enable bit and both programmed-request bits read 0, and both outputs are low when no peripheral line is high.
- R2: For each level, status bit k equals signal bit k AND enable bit k for k other than 1, and status bit 1 equals signal bit 1. `irq_out` is the OR of the normal status bits, and `fiq_out` is the OR of the fast status bits. Both are combinational from the lines.
- R3: Signal bits 2 and up of both levels follow `periph_req` in the same cycle, so signal bit k is `periph_req` line k. Signal bits 1 and 0 never come from `periph_req`.
- R4: A write to an enable register (normal 0x008, fast 0x108) sets each bit written as 1. Bits written as 0 keep their value.
- R5: A write to a clear register (normal 0x00C, fast 0x10C) clears each bit written as 1 in the matching enable register and leaves all other bits alone. Reading a clear register returns 0.
- R6: Setting an enable bit in one level clears the same bit in the other level. No bit is ever enabled at both levels.
- R7: `fiq_out` appears as signal bit 0 of both levels. The normal level therefore raises `irq_out` for a pending fast request when its enable bit 0 is set.
- R8: The programmed-request register at 0x200 keeps write-data bit 1 (normal) and bit 2 (fast). Each kept bit drives signal and status bit 1 of its level regardless of the masks. Reads return only those two bits, and all other bits read 0.
- R9: Status reads at 0x000 and 0x100 and signal reads at 0x004 and 0x104 are read-only. Writes there, and to any unmapped address, change no state, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| periph_req | input | 30 | Peripheral request lines for source positions 2 to 31 |
| bus_addr | input | 10 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Normal interrupt request to the core |
| fiq_out | output | 1 | Fast interrupt request to the core |

## Verification
The assertions assume that peripheral lines and bus inputs change only away from the rising clock edge. They also assume that at most one register is written per cycle, because the bus has a single address. The enable-set and enable-clear properties rely on this: they look only at the written bits one cycle later, since no second write can reach the same register in that cycle. The stimulus drives every input on the falling edge and issues one write per step. It also holds the peripheral lines steady across each write, so each property sees one clean cause.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Register byte offsets
  localparam int OFS_IRQ_STA = 'h000;
  localparam int OFS_IRQ_SIG = 'h004;
  localparam int OFS_IRQ_EN  = 'h008;
  localparam int OFS_IRQ_CLR = 'h00C;
  localparam int OFS_FIQ_STA = 'h100;
  localparam int OFS_FIQ_SIG = 'h104;
  localparam int OFS_FIQ_EN  = 'h108;
  localparam int OFS_FIQ_CLR = 'h10C;
  localparam int OFS_SWI     = 'h200;
  // Source positions with fixed meaning
  localparam int POS_LOOP = 0;
  localparam int POS_PROG = 1;
  localparam int POS_LINE = 2;
  // Programmed-request register fields
  localparam int SWI_IRQ_BIT = 1;
  localparam int SWI_FIQ_BIT = 2;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_core_n = stage2_q;
endmodule

// File: rtl/irqc_level.sv
module irqc_level #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_v,
  input  logic [N_SRC-1:0] clr_v,
  input  logic [N_SRC-1:0] kill_v,
  input  logic [N_SRC-1:2] line_in,
  input  logic             prog_in,
  input  logic             loop_in,
  output logic [N_SRC-1:0] en_q,
  output logic [N_SRC-1:0] sig_o,
  output logic [N_SRC-1:0] sta_o,
  output logic             req_hi
);
  import irqc_pkg::*;

  localparam logic [N_SRC-1:0] BYPASS = N_SRC'(1) << POS_PROG;

  logic [N_SRC-1:0] en_d;
  logic             en_ce;

  // Next state: clear beats set, cross-level kill beats both
  always_comb begin
    en_d  = ((en_q | set_v) & ~clr_v) & ~kill_v;
    en_ce = |{set_v, clr_v, kill_v};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (en_ce) begin
      en_q <= en_d;
    end
  end

  assign sig_o  = {line_in, prog_in, loop_in};
  assign sta_o  = sig_o & (en_q | BYPASS);
  // Request from positions 1 and up only; position 0 is added by the top
  assign req_hi = prog_in | (|(line_in & en_q[N_SRC-1:2]));
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic [N_SRC-1:0]  irq_sta,
  input  logic [N_SRC-1:0]  irq_sig,
  input  logic [N_SRC-1:0]  irq_en,
  input  logic [N_SRC-1:0]  fiq_sta,
  input  logic [N_SRC-1:0]  fiq_sig,
  input  logic [N_SRC-1:0]  fiq_en,
  output logic [N_SRC-1:0]  irq_set,
  output logic [N_SRC-1:0]  irq_clr,
  output logic [N_SRC-1:0]  fiq_set,
  output logic [N_SRC-1:0]  fiq_clr,
  output logic              swi_irq,
  output logic              swi_fiq,
  output logic [N_SRC-1:0]  bus_rdata
);
  import irqc_pkg::*;

  logic       hit_irq_en, hit_irq_clr, hit_fiq_en, hit_fiq_clr, hit_swi;
  logic [1:0] swi_q, swi_d;
  logic       swi_ce;

  always_comb begin
    hit_irq_en  = bus_we && (bus_addr == ADDR_W'(OFS_IRQ_EN));
    hit_irq_clr = bus_we && (bus_addr == ADDR_W'(OFS_IRQ_CLR));
    hit_fiq_en  = bus_we && (bus_addr == ADDR_W'(OFS_FIQ_EN));
    hit_fiq_clr = bus_we && (bus_addr == ADDR_W'(OFS_FIQ_CLR));
    hit_swi     = bus_we && (bus_addr == ADDR_W'(OFS_SWI));
    irq_set = hit_irq_en  ? bus_wdata : '0;
    irq_clr = hit_irq_clr ? bus_wdata : '0;
    fiq_set = hit_fiq_en  ? bus_wdata : '0;
    fiq_clr = hit_fiq_clr ? bus_wdata : '0;
    swi_ce  = hit_swi;
    swi_d   = {bus_wdata[SWI_FIQ_BIT], bus_wdata[SWI_IRQ_BIT]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swi_q <= '0;
    end else if (swi_ce) begin
      swi_q <= swi_d;
    end
  end

  assign swi_irq = swi_q[0];
  assign swi_fiq = swi_q[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_IRQ_STA): bus_rdata = irq_sta;
      ADDR_W'(OFS_IRQ_SIG): bus_rdata = irq_sig;
      ADDR_W'(OFS_IRQ_EN):  bus_rdata = irq_en;
      ADDR_W'(OFS_FIQ_STA): bus_rdata = fiq_sta;
      ADDR_W'(OFS_FIQ_SIG): bus_rdata = fiq_sig;
      ADDR_W'(OFS_FIQ_EN):  bus_rdata = fiq_en;
      ADDR_W'(OFS_SWI): begin
        bus_rdata[SWI_IRQ_BIT] = swi_q[0];
        bus_rdata[SWI_FIQ_BIT] = swi_q[1];
      end
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_irq_ctrl.sv
module dual_irq_ctrl #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:2]  periph_req,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [N_SRC-1:0]  bus_wdata,
  output logic [N_SRC-1:0]  bus_rdata,
  output logic              irq_out,
  output logic              fiq_out
);
  logic             rst_core_n;
  logic [N_SRC-1:0] irq_set, irq_clr, fiq_set, fiq_clr;
  logic [N_SRC-1:0] irq_kill, fiq_kill;
  logic [N_SRC-1:0] irq_en, irq_sig, irq_sta;
  logic [N_SRC-1:0] fiq_en, fiq_sig, fiq_sta;
  logic             irq_req_hi, fiq_req_hi;
  logic             swi_irq, swi_fiq;

  irqc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  irqc_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .irq_sta   (irq_sta),
    .irq_sig   (irq_sig),
    .irq_en    (irq_en),
    .fiq_sta   (fiq_sta),
    .fiq_sig   (fiq_sig),
    .fiq_en    (fiq_en),
    .irq_set   (irq_set),
    .irq_clr   (irq_clr),
    .fiq_set   (fiq_set),
    .fiq_clr   (fiq_clr),
    .swi_irq   (swi_irq),
    .swi_fiq   (swi_fiq),
    .bus_rdata (bus_rdata)
  );

  // Cross-level exclusion; a simultaneous set on both sides keeps the fast one
  assign irq_kill = fiq_set;
  assign fiq_kill = irq_set & ~fiq_set;

  irqc_level #(.N_SRC(N_SRC)) u_fiq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_v   (fiq_set),
    .clr_v   (fiq_clr),
    .kill_v  (fiq_kill),
    .line_in (periph_req),
    .prog_in (swi_fiq),
    .loop_in (fiq_out),
    .en_q    (fiq_en),
    .sig_o   (fiq_sig),
    .sta_o   (fiq_sta),
    .req_hi  (fiq_req_hi)
  );

  irqc_level #(.N_SRC(N_SRC)) u_irq (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .set_v   (irq_set),
    .clr_v   (irq_clr),
    .kill_v  (irq_kill),
    .line_in (periph_req),
    .prog_in (swi_irq),
    .loop_in (fiq_out),
    .en_q    (irq_en),
    .sig_o   (irq_sig),
    .sta_o   (irq_sta),
    .req_hi  (irq_req_hi)
  );

  // Fast position 0 only echoes fiq_out, so it cannot add to fiq_out
  assign fiq_out = fiq_req_hi;
  assign irq_out = irq_req_hi | irq_sta[0];
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_SRC-1:2]  periph_req,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [N_SRC-1:0]  bus_wdata,
  input logic [N_SRC-1:0]  irq_en,
  input logic [N_SRC-1:0]  fiq_en,
  input logic [N_SRC-1:0]  irq_sig,
  input logic [N_SRC-1:0]  fiq_sig,
  input logic              irq_out,
  input logic              fiq_out
);
  import irqc_pkg::*;

  logic wr_irq_en, wr_irq_clr, wr_fiq_en, wr_ro;
  assign wr_irq_en  = bus_we && bus_addr == ADDR_W'(OFS_IRQ_EN);
  assign wr_irq_clr = bus_we && bus_addr == ADDR_W'(OFS_IRQ_CLR);
  assign wr_fiq_en  = bus_we && bus_addr == ADDR_W'(OFS_FIQ_EN);
  assign wr_ro      = bus_we && (bus_addr == ADDR_W'(OFS_IRQ_STA) ||
                                 bus_addr == ADDR_W'(OFS_FIQ_SIG));

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |-> (irq_en == '0 && fiq_en == '0 && irq_sig[POS_PROG] == 1'b0 &&
                fiq_sig[POS_PROG] == 1'b0));

  assert_irq_or_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (|(irq_sig & irq_en) || irq_sig[POS_PROG]));

  assert_sig_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sig[N_SRC-1:2] == periph_req && fiq_sig[N_SRC-1:2] == periph_req);

  assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq_en |=> (irq_en & $past(bus_wdata)) == $past(bus_wdata));

  assert_en_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_irq_clr |=> ((irq_en & $past(bus_wdata)) == '0 &&
                    (irq_en & ~$past(bus_wdata)) == ($past(irq_en) & ~$past(bus_wdata))));

  assert_en_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en & fiq_en) == '0);

  assert_cross_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fiq_en |=> (irq_en & $past(bus_wdata)) == '0);

  assert_loopback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_sig[POS_LOOP] == fiq_out && fiq_sig[POS_LOOP] == fiq_out);

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ro |=> ($stable(irq_en) && $stable(fiq_en)));
endmodule

bind dual_irq_ctrl irqc_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .periph_req (periph_req),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .irq_en     (irq_en),
  .fiq_en     (fiq_en),
  .irq_sig    (irq_sig),
  .fiq_sig    (fiq_sig),
  .irq_out    (irq_out),
  .fiq_out    (fiq_out)
);

// File: tb/tb_dual_irq_ctrl.sv
module tb_dual_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:2] periph_req = '0;
  logic [9:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out, fiq_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_irq_ctrl dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .periph_req (periph_req),
    .bus_addr   (bus_addr),
    .bus_we     (bus_we),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .irq_out    (irq_out),
    .fiq_out    (fiq_out)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [9:0]  waddr;
    logic [31:0] wdata;
    logic [31:0] lines;
    logic [9:0]  raddr;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic        exp_fiq;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd3, 1'b0, 10'h000, 32'h0,        32'h000000F0, 10'h004, 32'h000000F0, 1'b0, 1'b0}, // R3 lines seen
    '{4'd2, 1'b1, 10'h008, 32'h00000030, 32'h000000F0, 10'h000, 32'h00000030, 1'b1, 1'b0}, // R2 masked
    '{4'd4, 1'b1, 10'h008, 32'h00000000, 32'h000000F0, 10'h008, 32'h00000030, 1'b1, 1'b0}, // R4 zero keeps
    '{4'd5, 1'b1, 10'h00C, 32'h00000010, 32'h000000F0, 10'h008, 32'h00000020, 1'b1, 1'b0}, // R5 one bit cleared
    '{4'd2, 1'b0, 10'h000, 32'h0,        32'h000000D0, 10'h000, 32'h00000000, 1'b0, 1'b0}, // R2 line drop
    '{4'd6, 1'b1, 10'h108, 32'h00000060, 32'h000000D0, 10'h008, 32'h00000000, 1'b0, 1'b1}, // R6 fast steals
    '{4'd7, 1'b0, 10'h000, 32'h0,        32'h000000D0, 10'h100, 32'h00000040, 1'b0, 1'b1}, // R7 fast status
    '{4'd7, 1'b0, 10'h000, 32'h0,        32'h000000D0, 10'h004, 32'h000000D1, 1'b0, 1'b1}, // R7 loop in normal
    '{4'd6, 1'b1, 10'h008, 32'h00000041, 32'h000000D0, 10'h108, 32'h00000020, 1'b1, 1'b0}, // R6 normal steals
    '{4'd7, 1'b0, 10'h000, 32'h0,        32'h000000F0, 10'h000, 32'h00000041, 1'b1, 1'b1}, // R7 loop enabled
    '{4'd5, 1'b1, 10'h10C, 32'h00000020, 32'h000000F0, 10'h108, 32'h00000000, 1'b1, 1'b0}, // R5 fast clear
    '{4'd5, 1'b1, 10'h00C, 32'hFFFFFFFF, 32'h000000F0, 10'h008, 32'h00000000, 1'b0, 1'b0}, // R5 clear all
    '{4'd8, 1'b1, 10'h200, 32'h00000002, 32'h00000000, 10'h000, 32'h00000002, 1'b1, 1'b0}, // R8 normal prog
    '{4'd8, 1'b1, 10'h200, 32'h00000004, 32'h00000000, 10'h104, 32'h00000003, 1'b0, 1'b1}, // R8 fast prog
    '{4'd7, 1'b0, 10'h000, 32'h0,        32'h00000000, 10'h004, 32'h00000001, 1'b0, 1'b1}, // R7 loop only
    '{4'd8, 1'b1, 10'h200, 32'hFFFFFFFF, 32'h00000000, 10'h200, 32'h00000006, 1'b1, 1'b1}, // R8 reserved zero
    '{4'd3, 1'b1, 10'h200, 32'h00000000, 32'hFFFFFFFC, 10'h004, 32'hFFFFFFFC, 1'b0, 1'b0}, // R3 low bits
    '{4'd9, 1'b1, 10'h000, 32'hFFFFFFFF, 32'h00000000, 10'h008, 32'h00000000, 1'b0, 1'b0}, // R9 status ro
    '{4'd5, 1'b1, 10'h008, 32'h80000000, 32'h80000000, 10'h00C, 32'h00000000, 1'b1, 1'b0}, // R5 clr reads 0
    '{4'd9, 1'b1, 10'h300, 32'hFFFFFFFF, 32'h80000000, 10'h108, 32'h00000000, 1'b1, 1'b0}, // R9 unmapped write
    '{4'd9, 1'b0, 10'h000, 32'h0,        32'h80000000, 10'h300, 32'h00000000, 1'b1, 1'b0}  // R9 unmapped read
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic read_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
    bus_we   = 1'b0;
    bus_addr = a;
    #1;
    check(tag, bus_rdata, exp);
  endtask

  task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: registers and outputs during reset
    read_chk("R1 en in reset", 10'h008, 32'h0);
    check("R1 irq in reset", {31'b0, irq_out}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1 irq en", 10'h008, 32'h0);
    read_chk("R1 fiq en", 10'h108, 32'h0);
    read_chk("R1 prog reg", 10'h200, 32'h0);
    read_chk("R1 irq sta", 10'h000, 32'h0);
    read_chk("R1 fiq sta", 10'h100, 32'h0);
    check("R1 outs", {30'b0, irq_out, fiq_out}, 32'h0);

    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      periph_req = VEC[i].lines[31:2];
      bus_we     = VEC[i].we;
      bus_addr   = VEC[i].waddr;
      bus_wdata  = VEC[i].wdata;
      @(posedge clk);
      @(negedge clk);
      bus_we   = 1'b0;
      bus_addr = VEC[i].raddr;
      #1;
      check($sformatf("R%0d vec %0d rdata", VEC[i].req, i), bus_rdata, VEC[i].exp_rd);
      check($sformatf("R%0d vec %0d irq", VEC[i].req, i), {31'b0, irq_out}, {31'b0, VEC[i].exp_irq});
      check($sformatf("R%0d vec %0d fiq", VEC[i].req, i), {31'b0, fiq_out}, {31'b0, VEC[i].exp_fiq});
    end

    // R2: outputs react to lines in the same cycle without a clock
    periph_req = '0;
    #1;
    check("R2 irq drops comb", {31'b0, irq_out}, 32'h0);

    // R1: reset mid-run wipes enables and programmed requests
    @(negedge clk);
    bus_write(10'h008, 32'h0000FF00);
    bus_write(10'h200, 32'h00000006);
    periph_req = 30'h3FC0;
    #1;
    check("R1 armed irq", {31'b0, irq_out}, 32'h1);
    rst_n = 1'b0;
    #1;
    check("R1 async irq low", {31'b0, irq_out}, 32'h0);
    check("R1 async fiq low", {31'b0, fiq_out}, 32'h0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_chk("R1 en after reset", 10'h008, 32'h0);
    read_chk("R1 prog after reset", 10'h200, 32'h0);
    read_chk("R3 lines after reset", 10'h004, 32'h0000FF00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule